// File: doc/BRIEF.md
# Cause Register Software-Write Controller

This block keeps the software-visible state of a 32-bit exception Cause register and applies processor writes to it. Only a small set of positions can be changed by a software write. Which positions those are depends on two revision inputs and, for one bit, on the value being written. Every other position is loaded from a separate side-load port, which hardware event logic uses to record pending hardware interrupts and exception codes.

The block also acts on what a write changes. When the count-disable bit is set, the cycle counter is told to stop. When that bit is cleared, the counter is told to run. Both a level and a one-cycle pulse are given for each transition. The two software interrupt-pending bits drive two interrupt request lines that follow them.

Top module: `cause_wr_ctrl`

## Requirements
- R1: After reset, `cause_o` is 0, `cnt_run` is 1, `swi_req` is 0, and both `cnt_stop_p` and `cnt_start_p` are 0.
- R2: A software write (`wr_en` high) updates bit 23 (interrupt-vector select), bit 22 (watch-pending) and bits 9:8 (software interrupt-pending) from `wr_data`. The result shows on `cause_o` in the cycle after the write. Bit 22 is subject to R4.
- R3: Bit 27 (count-disable) takes `wr_data[27]` when `rev_r2` or `rev_r6` is high. When both are low, bit 27 keeps its value on a write.
- R4: When `rev_r6` is high, a write with `wr_data[22]`=0 clears bit 22, and a write with `wr_data[22]`=1 leaves bit 22 unchanged.
- R5: `cnt_run` equals the inverse of `cause_o[27]`. It changes in the same cycle that `cause_o[27]` changes.
- R6: A write that changes bit 27 from 0 to 1 raises `cnt_stop_p` for exactly one cycle. A write that changes it from 1 to 0 raises `cnt_start_p` for exactly one cycle. Each pulse appears in the cycle after the write.
- R7: `swi_req[i]` equals `cause_o[8+i]` for i = 0 and 1. It is updated in the cycle after a write that changes that bit.
- R8: A cycle with neither `wr_en` nor `ld_en` high leaves `cause_o`, `cnt_run` and `swi_req` unchanged and produces no pulse. A write that leaves bit 27 unchanged produces no pulse.
- R9: A software write never alters any bit other than 27, 23, 22, 9 and 8. When `ld_en` is high, `ld_data` replaces all bits except those five, which `ld_en` never touches. Both ports may be used in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write data |
| rev_r2 | input | 1 | Revision 2 or later features enabled |
| rev_r6 | input | 1 | Revision 6 write rules enabled |
| ld_en | input | 1 | Hardware side-load strobe |
| ld_data | input | 32 | Side-load data for hardware-owned bits |
| cause_o | output | 32 | Current Cause register value |
| cnt_run | output | 1 | Counter enable level (inverse of count-disable) |
| cnt_stop_p | output | 1 | One-cycle pulse: counter stopped by a write |
| cnt_start_p | output | 1 | One-cycle pulse: counter restarted by a write |
| swi_req | output | 2 | Software interrupt request lines |

## Verification
A wrong writable mask, or a wrong revision decode, shows on `cause_o` in the cycle right after the offending write. For that reason every data pattern for the five software-owned positions is written under each of the four revision settings, and each write is compared with an arithmetic model. The counter-enable level and the interrupt lines are held in their own flops. If they drift from the register bits, the fault shows as a mismatch on the same sampled cycle. The bench watches for a stuck or doubled pulse in the idle cycle that follows every write. Side-load and combined side-load-plus-write cycles confirm that the two field sets stay apart.

// File: rtl/cause_pkg.sv
package cause_pkg;

    localparam int unsigned CAUSE_W = 32;
    localparam int unsigned NUM_SWI = 2;
    localparam int unsigned DC_BIT  = 27;
    localparam int unsigned IV_BIT  = 23;
    localparam int unsigned WP_BIT  = 22;
    localparam int unsigned SWI_LSB = 8;

    // Bits that belong to software; everything else is side-loaded.
    function automatic logic [CAUSE_W-1:0] sw_field_mask();
        logic [CAUSE_W-1:0] m;
        m = '0;
        m[DC_BIT] = 1'b1;
        m[IV_BIT] = 1'b1;
        m[WP_BIT] = 1'b1;
        for (int i = 0; i < int'(NUM_SWI); i++) begin
            m[SWI_LSB + i] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [CAUSE_W-1:0] SW_FIELDS = sw_field_mask();

    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
        logic               run;
        logic               stop_p;
        logic               start_p;
        logic [NUM_SWI-1:0] swi;
    } ctrl_state_t;

endpackage

// File: rtl/cause_mask_gen.sv
module cause_mask_gen
    import cause_pkg::*;
(
    input  logic               rev_r2,
    input  logic               rev_r6,
    input  logic               wp_wr_bit,
    output logic [CAUSE_W-1:0] mask_o
);
    always_comb begin
        mask_o = '0;
        mask_o[IV_BIT] = 1'b1;
        mask_o[WP_BIT] = 1'b1;
        for (int i = 0; i < int'(NUM_SWI); i++) begin
            mask_o[SWI_LSB + i] = 1'b1;
        end
        // Count-disable exists from revision 2 onward (R6 implies it).
        if (rev_r2 || rev_r6) begin
            mask_o[DC_BIT] = 1'b1;
        end
        // Later revision: watch-pending may only be cleared by software.
        if (rev_r6 && wp_wr_bit) begin
            mask_o[WP_BIT] = 1'b0;
        end
    end
endmodule

// File: rtl/cause_bit_track.sv
module cause_bit_track (
    input  logic old_bit,
    input  logic new_bit,
    output logic rise_o,
    output logic fall_o
);
    always_comb begin
        rise_o = !old_bit &&  new_bit;
        fall_o =  old_bit && !new_bit;
    end
endmodule

// File: rtl/cause_wr_ctrl.sv
module cause_wr_ctrl
    import cause_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CAUSE_W-1:0] wr_data,
    input  logic               rev_r2,
    input  logic               rev_r6,
    input  logic               ld_en,
    input  logic [CAUSE_W-1:0] ld_data,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               cnt_run,
    output logic               cnt_stop_p,
    output logic               cnt_start_p,
    output logic [NUM_SWI-1:0] swi_req
);
    ctrl_state_t st_q, st_d;

    logic [CAUSE_W-1:0] wr_mask;
    logic [CAUSE_W-1:0] merged;
    logic               dc_rise, dc_fall;
    logic [NUM_SWI-1:0] swi_rise, swi_fall;

    cause_mask_gen u_mask (
        .rev_r2    (rev_r2),
        .rev_r6    (rev_r6),
        .wp_wr_bit (wr_data[WP_BIT]),
        .mask_o    (wr_mask)
    );

    always_comb begin
        merged = st_q.cause;
        if (ld_en) begin
            merged = (merged & SW_FIELDS) | (ld_data & ~SW_FIELDS);
        end
        if (wr_en) begin
            merged = (merged & ~wr_mask) | (wr_data & wr_mask);
        end
    end

    cause_bit_track u_dc (
        .old_bit (st_q.cause[DC_BIT]),
        .new_bit (merged[DC_BIT]),
        .rise_o  (dc_rise),
        .fall_o  (dc_fall)
    );

    for (genvar g = 0; g < NUM_SWI; g++) begin : g_swi
        cause_bit_track u_trk (
            .old_bit (st_q.cause[SWI_LSB + g]),
            .new_bit (merged[SWI_LSB + g]),
            .rise_o  (swi_rise[g]),
            .fall_o  (swi_fall[g])
        );
    end

    always_comb begin
        st_d         = st_q;
        st_d.cause   = merged;
        st_d.stop_p  = wr_en && dc_rise;
        st_d.start_p = wr_en && dc_fall;
        if (wr_en && dc_rise) begin
            st_d.run = 1'b0;
        end else if (wr_en && dc_fall) begin
            st_d.run = 1'b1;
        end
        for (int i = 0; i < int'(NUM_SWI); i++) begin
            if (wr_en && swi_rise[i]) begin
                st_d.swi[i] = 1'b1;
            end else if (wr_en && swi_fall[i]) begin
                st_d.swi[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cause   <= '0;
            st_q.run     <= 1'b1;
            st_q.stop_p  <= 1'b0;
            st_q.start_p <= 1'b0;
            st_q.swi     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_o     = st_q.cause;
    assign cnt_run     = st_q.run;
    assign cnt_stop_p  = st_q.stop_p;
    assign cnt_start_p = st_q.start_p;
    assign swi_req     = st_q.swi;

endmodule

// File: rtl/cause_wr_ctrl_chk.sv
module cause_wr_ctrl_chk
    import cause_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CAUSE_W-1:0] wr_data,
    input  logic               rev_r2,
    input  logic               rev_r6,
    input  logic               ld_en,
    input  logic [CAUSE_W-1:0] ld_data,
    input  logic [CAUSE_W-1:0] cause_o,
    input  logic               cnt_run,
    input  logic               cnt_stop_p,
    input  logic               cnt_start_p,
    input  logic [NUM_SWI-1:0] swi_req
);
    p_run_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_run == !cause_o[DC_BIT]);

    p_pulse_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnt_stop_p && cnt_start_p));

    p_stop_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !cause_o[DC_BIT] && wr_data[DC_BIT] && (rev_r2 || rev_r6)
        |=> cnt_stop_p && cause_o[DC_BIT]);

    p_start_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && cause_o[DC_BIT] && !wr_data[DC_BIT] && (rev_r2 || rev_r6)
        |=> cnt_start_p && !cause_o[DC_BIT]);

    p_swi_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        swi_req == cause_o[SWI_LSB +: NUM_SWI]);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && !ld_en |=> $stable(cause_o) && !cnt_stop_p && !cnt_start_p);

    p_dc_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !rev_r2 && !rev_r6 |=> $stable(cause_o[DC_BIT]));

    p_wp_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && rev_r6 && wr_data[WP_BIT] |=> $stable(cause_o[WP_BIT]));

    p_hw_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> $stable(cause_o & ~SW_FIELDS));
endmodule

bind cause_wr_ctrl cause_wr_ctrl_chk u_chk (.*);

// File: tb/tb_cause_wr_ctrl.sv
`timescale 1ns/1ps
module tb_cause_wr_ctrl;
    localparam logic [31:0] SWF = 32'h08C0_0300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rev_r2 = 1'b0;
    logic        rev_r6 = 1'b0;
    logic        ld_en = 1'b0;
    logic [31:0] ld_data = '0;
    logic [31:0] cause_o;
    logic        cnt_run, cnt_stop_p, cnt_start_p;
    logic [1:0]  swi_req;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] model = '0;

    always #4 clk = ~clk;

    cause_wr_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rev_r2(rev_r2), .rev_r6(rev_r6), .ld_en(ld_en), .ld_data(ld_data),
        .cause_o(cause_o), .cnt_run(cnt_run), .cnt_stop_p(cnt_stop_p),
        .cnt_start_p(cnt_start_p), .swi_req(swi_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] wmask(input logic r2, input logic r6, input logic [31:0] d);
        logic [31:0] m;
        m = 32'h00C0_0300;
        if (r2 || r6) m[27] = 1'b1;
        if (r6 && d[22]) m[22] = 1'b0;
        return m;
    endfunction

    task automatic check_all(input string req, input logic stop_e, input logic start_e);
        chk({req, " cause"}, cause_o, model);
        chk("R5 run", {31'd0, cnt_run}, {31'd0, !model[27]});
        chk("R7 swi", {30'd0, swi_req}, {30'd0, model[9:8]});
        chk("R6 stop", {31'd0, cnt_stop_p}, {31'd0, stop_e});
        chk("R6 start", {31'd0, cnt_start_p}, {31'd0, start_e});
    endtask

    // Write, check the cycle after, then an idle cycle (pulse gone, state held).
    task automatic do_cycle(input logic we, input logic [31:0] d, input logic r2, input logic r6,
                            input logic le, input logic [31:0] ld, input string req);
        logic [31:0] old, m;
        @(negedge clk);
        wr_en = we; wr_data = d; rev_r2 = r2; rev_r6 = r6; ld_en = le; ld_data = ld;
        old = model;
        if (le) model = (model & SWF) | (ld & ~SWF);
        if (we) begin
            m = wmask(r2, r6, d);
            model = (model & ~m) | (d & m);
        end
        @(negedge clk);
        wr_en = 1'b0; ld_en = 1'b0;
        check_all(req, we && !old[27] && model[27], we && old[27] && !model[27]);
        @(negedge clk);
        check_all("R8 idle", 1'b0, 1'b0);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cause", cause_o, 32'h0);
        chk("R1 run", {31'd0, cnt_run}, 32'd1);
        chk("R1 swi", {30'd0, swi_req}, 32'd0);
        chk("R1 pulses", {30'd0, cnt_stop_p, cnt_start_p}, 32'd0);

        // R2 R3 R4 R6 R7 R8 R9: every software-field pattern under every revision
        for (int rv = 0; rv < 4; rv++) begin
            for (int p = 0; p < 32; p++) begin
                logic [31:0] d;
                d = (p + 1) * 32'h9E37_79B1 ^ (rv * 32'h1357_9BDF);
                d[8]  = p[0];
                d[9]  = p[1];
                d[22] = p[2];
                d[23] = p[3];
                d[27] = p[4];
                do_cycle(1'b1, d, rv[0], rv[1], 1'b0, 32'h0, "R2 R3 R4 R9 sweep");
            end
        end

        // R4: set WP on an older revision, then try set/clear under R6
        do_cycle(1'b1, 32'h0040_0000, 1'b0, 1'b0, 1'b0, 32'h0, "R2 wp set");
        do_cycle(1'b1, 32'h0040_0000, 1'b1, 1'b1, 1'b0, 32'h0, "R4 wp one kept");
        do_cycle(1'b1, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 32'h0, "R4 wp cleared");

        // R9: side-load alone, then together with a write
        do_cycle(1'b0, 32'h0, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, "R9 load ones");
        do_cycle(1'b0, 32'h0, 1'b1, 1'b0, 1'b1, 32'hA5A5_5A5A, "R9 load pat");
        do_cycle(1'b1, 32'h0880_0100, 1'b1, 1'b0, 1'b1, 32'h1234_5678, "R9 load+write");
        do_cycle(1'b1, 32'h0000_0000, 1'b1, 1'b0, 1'b1, 32'h0000_0000, "R9 load+clear");

        // R8: repeated identical writes produce no pulses
        do_cycle(1'b1, 32'h0800_0000, 1'b1, 1'b0, 1'b0, 32'h0, "R6 stop");
        do_cycle(1'b1, 32'h0800_0000, 1'b1, 1'b0, 1'b0, 32'h0, "R8 same dc");
        do_cycle(1'b0, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, "R8 no strobe");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule